// File: doc/BRIEF.md
# PLL Control Register with Lock-Change Interrupt

This block is a single 8-bit control and status register for a phase-locked loop. Software reaches it over a plain synchronous register bus: a select, a write strobe, a read strobe, write data and read data. Every access completes in the cycle it is presented. There is no back-pressure, and read data is combinational from the register state in the cycle of the read strobe. The register drives the loop enable, the base clock source select, a 2-bit prescaler and a 2-bit VCO range code straight to the clock generator.

The block watches the raw lock indicator from the loop. It resynchronizes the indicator, and every change in either direction sets a sticky lock-change flag. When the flag and its enable are both 1, the block raises an interrupt request. Software clears the flag by reading the register. The enable bit, the flag and the interrupt are visible only while the automatic-bandwidth mode input is 1.

The loop enable is protected. A write cannot turn the loop off while the loop clock drives the base clock, so software cannot remove the clock it is running from.

Top module: `pllctl_top`

## Requirements
- R1: After reset the register reads 0x20, with the loop enable set and all other bits 0, and the interrupt request is low.
- R2: Bit layout, from MSB to LSB: bit 7 interrupt enable, bit 6 lock-change flag, bit 5 loop enable, bit 4 base clock select, bits 3:2 prescaler, bits 1:0 VCO range. A write stores bits 7, 5, 4, 3:2 and 1:0, subject to R9 and R10.
- R3: A rising edge on the lock input sets the flag. The lock input passes through two synchronizer flops, so the flag reads 1 after the third rising clock edge following the change.
- R4: A falling edge on the lock input also sets the flag, with the same latency as R3.
- R5: Any read clears the flag at the end of the read cycle. The data returned by that read shows the flag value from before the clear.
- R6: If a lock edge is detected in the same cycle as a clearing read, the flag ends at 1.
- R7: Write data in bit 6 is discarded. The flag cannot be set by software.
- R8: The interrupt request is high exactly while automatic mode, the interrupt enable and the flag are all 1.
- R9: While automatic mode is 0, writes to the interrupt enable leave its stored value unchanged. Bits 7 and 6 read as 0 and the interrupt request is low.
- R10: A write that would clear the loop enable is ignored while the stored base clock select is 1. The value of base clock select from before the write decides this, so one write that sets bit 4 and clears bit 5 does clear the loop enable.
- R11: Read data is 0x00 in any cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register select |
| wr_stb | input | 1 | Write strobe, used when sel is 1 |
| rd_stb | input | 1 | Read strobe, used when sel is 1 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the read-strobe cycle |
| lock_raw | input | 1 | Asynchronous lock indicator from the loop |
| auto_mode | input | 1 | Automatic-bandwidth mode |
| pll_on_o | output | 1 | Loop enable |
| clk_sel_o | output | 1 | Base clock select, 1 selects the loop clock |
| prescale_o | output | 2 | Prescaler code |
| vco_range_o | output | 2 | VCO range code |
| irq_o | output | 1 | Lock-change interrupt request |

## Verification
The hardest case to reach from the ports is a clearing read that lands in the same cycle as a detected lock edge. That edge appears only after the synchronizer delay. The bench changes the lock input at a falling clock edge, counts exactly two rising edges, and then issues the read. That read must still return the old flag value, and a read that follows must return the flag set. A second case needs care: reading the masked flag while automatic mode is 0 still clears it. The bench checks this by enabling automatic mode again afterwards and reading the register.

// File: rtl/pllctl_pkg.sv
package pllctl_pkg;
  localparam int REG_W   = 8;
  localparam int BIT_IE  = 7;
  localparam int BIT_FLG = 6;
  localparam int BIT_ON  = 5;
  localparam int BIT_BCS = 4;
  localparam int PRE_LO  = 2;
  localparam int PRE_W   = 2;
  localparam int VPR_LO  = 0;
  localparam int VPR_W   = 2;
  localparam logic [REG_W-1:0] RESET_VIEW = 8'h20;

  typedef struct packed {
    logic             ie;
    logic             flag;
    logic             on;
    logic             bcs;
    logic [PRE_W-1:0] pre;
    logic [VPR_W-1:0] vpr;
  } ctl_reg_t;
endpackage

// File: rtl/pllctl_lock_edge.sv
module pllctl_lock_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_raw,
  output logic edge_pulse
);
  localparam int LAST = SYNC_STAGES;

  // stages 0..SYNC_STAGES-1 synchronize, stage LAST holds the previous value
  logic [LAST:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LAST-1:0], lock_raw};
  end

  assign edge_pulse = chain_q[LAST] ^ chain_q[LAST-1];
endmodule

// File: rtl/pllctl_regfile.sv
module pllctl_regfile
  import pllctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             auto_mode,
  input  logic             edge_pulse,
  output ctl_reg_t         state_q
);
  ctl_reg_t nxt;
  logic     unused_bit6;

  assign unused_bit6 = wdata[BIT_FLG];

  always_comb begin
    nxt = state_q;
    if (wr_en) begin
      if (auto_mode) nxt.ie = wdata[BIT_IE];
      // the loop enable stays up while the old select points at the loop clock
      nxt.on  = wdata[BIT_ON] | (state_q.bcs & state_q.on);
      nxt.bcs = wdata[BIT_BCS];
      nxt.pre = wdata[PRE_LO +: PRE_W];
      nxt.vpr = wdata[VPR_LO +: VPR_W];
    end
    if (rd_en)      nxt.flag = 1'b0;
    if (edge_pulse) nxt.flag = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ctl_reg_t'(RESET_VIEW);
    else        state_q <= nxt;
  end
endmodule

// File: rtl/pllctl_top.sv
module pllctl_top
  import pllctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             lock_raw,
  input  logic             auto_mode,
  output logic             pll_on_o,
  output logic             clk_sel_o,
  output logic [PRE_W-1:0] prescale_o,
  output logic [VPR_W-1:0] vco_range_o,
  output logic             irq_o
);
  logic     wr_en, rd_en, edge_pulse;
  ctl_reg_t state_q;
  ctl_reg_t view;

  assign wr_en = sel & wr_stb;
  assign rd_en = sel & rd_stb;

  pllctl_lock_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .lock_raw(lock_raw), .edge_pulse(edge_pulse)
  );

  pllctl_regfile u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .auto_mode(auto_mode), .edge_pulse(edge_pulse), .state_q(state_q)
  );

  always_comb begin
    view      = state_q;
    view.ie   = state_q.ie & auto_mode;
    view.flag = state_q.flag & auto_mode;
  end

  assign rdata       = rd_en ? REG_W'(view) : '0;
  assign irq_o       = view.ie & view.flag;
  assign pll_on_o    = state_q.on;
  assign clk_sel_o   = state_q.bcs;
  assign prescale_o  = state_q.pre;
  assign vco_range_o = state_q.vpr;
endmodule

// File: rtl/pllctl_checker.sv
module pllctl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       edge_pulse,
  input logic       auto_mode,
  input logic       pll_on_o,
  input logic       clk_sel_o,
  input logic       irq_o
);
  AST_ON_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && clk_sel_o && pll_on_o) |=> pll_on_o); // R10

  AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_pulse && auto_mode) ##1 (rd_en && auto_mode) |-> rdata[6]); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !edge_pulse) ##1 (rd_en && auto_mode) |-> !rdata[6]); // R5

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_mode |-> !irq_o); // R9

  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == 8'h00)); // R11

  AST_NO_SW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[6] && !edge_pulse) ##1 (rd_en && auto_mode) |-> !rdata[6]); // R7
endmodule

bind pllctl_top pllctl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
  .rdata(rdata), .edge_pulse(edge_pulse), .auto_mode(auto_mode),
  .pll_on_o(pll_on_o), .clk_sel_o(clk_sel_o), .irq_o(irq_o)
);

// File: tb/tb_pllctl_top.sv
`timescale 1ns/1ps
module tb_pllctl_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       lock_raw = 1'b0, auto_mode = 1'b1;
  logic       pll_on_o, clk_sel_o, irq_o;
  logic [1:0] prescale_o, vco_range_o;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  pllctl_top dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wdata(wdata), .rdata(rdata), .lock_raw(lock_raw), .auto_mode(auto_mode),
    .pll_on_o(pll_on_o), .clk_sel_o(clk_sel_o), .prescale_o(prescale_o),
    .vco_range_o(vco_range_o), .irq_o(irq_o)
  );

  // {auto, do_write, wdata, expected read}
  localparam int NV = 10;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b1, 8'h00, 8'h00},   // R2 clear all
    {1'b1, 1'b1, 8'hFF, 8'hBF},   // R2 R7 bit 6 dropped
    {1'b1, 1'b1, 8'h10, 8'h30},   // R10 clear of loop enable refused
    {1'b1, 1'b1, 8'h0D, 8'h2D},   // R10 old select still 1
    {1'b1, 1'b1, 8'h05, 8'h05},   // R10 old select 0, clear accepted
    {1'b1, 1'b1, 8'h90, 8'h90},   // R10 set select and clear enable together
    {1'b1, 1'b1, 8'h80, 8'h80},   // R2 enable stays off
    {1'b0, 1'b1, 8'h00, 8'h00},   // R9 masked view, write to bit 7 dropped
    {1'b1, 1'b0, 8'h00, 8'h80},   // R9 stored enable kept
    {1'b1, 1'b1, 8'h20, 8'h20}    // R2
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    sel = 1'b1; wr_stb = 1'b1; wdata = d;
    @(posedge clk); @(negedge clk);
    sel = 1'b0; wr_stb = 1'b0; wdata = 8'h00;
  endtask

  task automatic do_read(input string req, input logic [7:0] exp);
    sel = 1'b1; rd_stb = 1'b1;
    #1 check(req, rdata, exp);
    @(posedge clk); @(negedge clk);
    sel = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic toggle_lock(input int waits);
    lock_raw = ~lock_raw;
    repeat (waits) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 irq", {7'd0, irq_o}, 8'h00);
    check("R1 enable", {7'd0, pll_on_o}, 8'h01);
    do_read("R1 reset value", 8'h20);

    for (int i = 0; i < NV; i++) begin
      auto_mode = VEC[i][17];
      if (VEC[i][16]) do_write(VEC[i][15:8]);
      do_read($sformatf("R2/R7/R9/R10 vector %0d", i), VEC[i][7:0]);
    end
    check("R10 clk_sel pin", {7'd0, clk_sel_o}, 8'h00);

    #1 check("R11 idle rdata", rdata, 8'h00);

    do_write(8'hA0);
    toggle_lock(3);
    #1 check("R8 irq high", {7'd0, irq_o}, 8'h01);
    do_read("R3 rise sets flag", 8'hE0);
    #1 check("R8 irq low after clear", {7'd0, irq_o}, 8'h00);
    do_read("R5 read cleared flag", 8'hA0);

    toggle_lock(2);
    #1 check("R3 not yet after two edges", {7'd0, irq_o}, 8'h00);
    @(posedge clk); @(negedge clk);
    do_read("R4 fall sets flag", 8'hE0);

    toggle_lock(3);
    auto_mode = 1'b0;
    #1 check("R9 irq masked", {7'd0, irq_o}, 8'h00);
    do_read("R9 flag and enable read 0", 8'h20);
    auto_mode = 1'b1;
    do_read("R5 masked read still cleared", 8'hA0);

    toggle_lock(2);
    do_read("R6 read in edge cycle shows old", 8'hA0);
    do_read("R6 set wins over clear", 8'hE0);

    do_write(8'h60);
    do_read("R7 software cannot set flag", 8'h20);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected finish");
      finish_run();
    end
  end
endmodule